// File: doc/BRIEF.md
# Controller Operating Mode Sequencer

This block decides the operating mode of a CAN-style protocol controller. It has four modes: sleep, reset, halt and operation. Software selects the mode through a 16-bit control word and reads the mode that is actually in force from a 16-bit status word.

Mode changes do not happen on the write itself. A requested change waits a programmable settle time, so software polls the status word until the new mode shows. There are two exceptions:

- A forced reset takes effect on the next clock edge.
- A bus-off pulse from the protocol engine can drop the controller into halt at once, if that recovery option is selected.

A plain reset request from the bus-facing side also waits for the bus to go idle. The block drives a configuration-open signal while it is in reset. Timing and mailbox registers elsewhere in the chip use this signal as their write gate. The low format bits of the control word are gated the same way.

Top module: `opmode_seq`

## Requirements
- R1: After hardware reset the control word reads 0x0500 (sleep bit 10 set, mode request 01), the status word reads 0x0400 and cfgOpen is 0.
- R2: The status word shows the mode in force and keeps every other bit at 0. Bit 8 is set in reset, bit 9 in halt and bit 10 in sleep. In operation the word is 0x0000, so at most one of bits 10:8 is set.
- R3: The mode request in bits 9:8 is decoded as 00 operation, 01 reset, 10 halt and 11 forced reset. A change that is neither forced nor caused by bus-off takes effect on exactly the SETTLE_CYCLES-th rising edge after the edge that wrote the control word.
- R4: A forced reset request (11) puts the controller in reset on the first edge after the write, whatever the bus state.
- R5: A plain reset request (01) takes effect only on an edge where busIdle is 1. Once the settle time has passed, it commits on the first such edge.
- R6: Bits 12:8 of the control word are writable in every mode. Bits 3:0 (bit 3 message-lost mode, bits 2:1 ID format, bit 0 FIFO mailbox mode) are written only while the mode in force is reset. Bits 15:13 and 7:4 always read 0.
- R7: cfgOpen is 1 exactly while the mode in force is reset.
- R8: The sleep bit (bit 10) is honoured only from halt or reset. While the controller is in operation with the sleep bit set, it keeps following the mode request.
- R9: When the sleep bit is cleared during sleep, the controller leaves sleep for the requested mode after the settle time.
- R10: A bus-off pulse while in operation, with the recovery field (bits 12:11) at 01, moves the controller to halt on the next edge and sets the request bits 9:8 to 10. With any other recovery value the pulse is ignored.
- R11: If the requested target changes before the settle time has passed, the count restarts, and the earlier target never takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWrEn | input | 1 | Control word write strobe |
| ctlWrData | input | 16 | Control word write data |
| busIdle | input | 1 | Protocol engine reports the bus idle |
| busOffPulse | input | 1 | One-cycle bus-off entry event |
| ctlRdData | output | 16 | Current control word |
| statusRdData | output | 16 | Current status word |
| cfgOpen | output | 1 | Configuration writes allowed (reset mode) |

## Verification
The bench builds the block with SETTLE_CYCLES set to 3. With that value each normal transition commits on the third edge after the write, so the bench can check the old mode on the edge before the commit and the new mode on the commit edge itself. It sweeps every pairing of a starting mode (operation, halt, reset) with each of the four request codes, and computes the expected mode and commit edge for each pairing. The short settle time also keeps the longer cases quick:

- a two-step sleep entry through halt;
- a reset held off by a busy bus;
- a target changed mid-count.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_RESET = 2'd1,
    MODE_HALT  = 2'd2,
    MODE_OPER  = 2'd3
  } opMode_e;

  typedef struct packed {
    logic    commit;
    opMode_e nextMode;
    logic    busOffHalt;
  } modeStrobe_t;

  localparam int CTL_W       = 16;
  localparam int SLEEP_BIT   = 10;
  localparam int REQ_LO      = 8;
  localparam int RECOV_LO    = 11;
  localparam logic [CTL_W-1:0] CTL_RESET_VAL = 16'h0500;
  localparam logic [CTL_W-1:0] CTL_ALWAYS_MASK = 16'h1F00;
  localparam logic [CTL_W-1:0] CTL_FMT_MASK = 16'h000F;
  localparam logic [1:0] REQ_OPER   = 2'b00;
  localparam logic [1:0] REQ_RESET  = 2'b01;
  localparam logic [1:0] REQ_HALT   = 2'b10;
  localparam logic [1:0] REQ_FORCE  = 2'b11;
  localparam logic [1:0] RECOV_AUTO_HALT = 2'b01;

endpackage

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTL_W-1:0]  ctlReg,
  input  opMode_e           curMode,
  input  logic              busIdle,
  input  logic              busOffPulse,
  output modeStrobe_t       strobe
);

  localparam int CNT_W = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [1:0]       reqField;
  logic [1:0]       recovField;
  logic             sleepReq;
  opMode_e          reqMode;
  opMode_e          targetMode;
  logic             forcedNow;
  logic             boHalt;
  logic             settled;
  logic             gateOk;
  logic             pending;
  opMode_e          pendMode;
  logic [CNT_W-1:0] waitCnt;

  assign reqField   = ctlReg[REQ_LO +: 2];
  assign recovField = ctlReg[RECOV_LO +: 2];
  assign sleepReq   = ctlReg[SLEEP_BIT];

  always_comb begin
    unique case (reqField)
      REQ_OPER: reqMode = MODE_OPER;
      REQ_HALT: reqMode = MODE_HALT;
      default:  reqMode = MODE_RESET;
    endcase
  end

  // Sleep is only reachable from a quiet mode; from operation the request field rules.
  assign targetMode = (sleepReq && (curMode != MODE_OPER)) ? MODE_SLEEP : reqMode;
  assign forcedNow  = (targetMode == MODE_RESET) && (reqField == REQ_FORCE) &&
                      (curMode != MODE_RESET);
  assign boHalt     = busOffPulse && (curMode == MODE_OPER) &&
                      (recovField == RECOV_AUTO_HALT) && !forcedNow;
  assign settled    = pending && (pendMode == targetMode) && (waitCnt == CNT_LAST);
  assign gateOk     = (targetMode != MODE_RESET) || busIdle;

  always_comb begin
    strobe.busOffHalt = boHalt;
    strobe.commit     = forcedNow || boHalt ||
                        ((targetMode != curMode) && settled && gateOk);
    if (forcedNow)   strobe.nextMode = MODE_RESET;
    else if (boHalt) strobe.nextMode = MODE_HALT;
    else             strobe.nextMode = targetMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      pendMode <= MODE_SLEEP;
      waitCnt  <= '0;
    end else if ((targetMode == curMode) || strobe.commit) begin
      pending  <= 1'b0;
      waitCnt  <= '0;
    end else if (!pending || (pendMode != targetMode)) begin
      pending  <= 1'b1;
      pendMode <= targetMode;
      waitCnt  <= CNT_W'(1);
    end else if (waitCnt != CNT_LAST) begin
      waitCnt  <= waitCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/opmode_dp.sv
module opmode_dp
  import opmode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrData,
  input  modeStrobe_t       strobe,
  output logic [CTL_W-1:0]  ctlReg,
  output opMode_e           curMode,
  output logic [CTL_W-1:0]  statusReg,
  output logic              cfgOpen
);

  logic [CTL_W-1:0] wrMask;
  logic [CTL_W-1:0] ctlNext;

  assign wrMask = (curMode == MODE_RESET) ? (CTL_ALWAYS_MASK | CTL_FMT_MASK)
                                          : CTL_ALWAYS_MASK;

  always_comb begin
    ctlNext = ctlReg;
    if (ctlWrEn) ctlNext = (ctlWrData & wrMask) | (ctlReg & ~wrMask);
    if (strobe.busOffHalt) ctlNext[REQ_LO +: 2] = REQ_HALT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg  <= CTL_RESET_VAL;
      curMode <= MODE_SLEEP;
    end else begin
      ctlReg <= ctlNext;
      if (strobe.commit) curMode <= strobe.nextMode;
    end
  end

  always_comb begin
    statusReg = '0;
    statusReg[8]  = (curMode == MODE_RESET);
    statusReg[9]  = (curMode == MODE_HALT);
    statusReg[10] = (curMode == MODE_SLEEP);
  end

  assign cfgOpen = (curMode == MODE_RESET);

endmodule

// File: rtl/opmode_seq.sv
module opmode_seq
  import opmode_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWrEn,
  input  logic [15:0] ctlWrData,
  input  logic        busIdle,
  input  logic        busOffPulse,
  output logic [15:0] ctlRdData,
  output logic [15:0] statusRdData,
  output logic        cfgOpen
);

  modeStrobe_t strobe;
  opMode_e     curMode;

  opmode_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlReg(ctlRdData), .curMode(curMode),
    .busIdle(busIdle), .busOffPulse(busOffPulse), .strobe(strobe)
  );

  opmode_dp u_dp (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .strobe(strobe), .ctlReg(ctlRdData), .curMode(curMode),
    .statusReg(statusRdData), .cfgOpen(cfgOpen)
  );

endmodule

// File: rtl/opmode_seq_chk.sv
module opmode_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busIdle,
  input logic        busOffPulse,
  input logic [15:0] ctlRdData,
  input logic [15:0] statusRdData
);

  assert_status_shape_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(statusRdData[10:8]) && (statusRdData[15:11] == 5'd0) &&
    (statusRdData[7:0] == 8'd0));

  assert_forced_reset_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!statusRdData[8] && (ctlRdData[9:8] == 2'b11) &&
     (!ctlRdData[10] || (statusRdData == 16'h0000))) |=> statusRdData[8]);

  assert_reset_waits_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statusRdData[8]) && ($past(ctlRdData[9:8]) == 2'b01)) |-> $past(busIdle));

  assert_fmt_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    !statusRdData[8] |=> $stable(ctlRdData[3:0]));

  assert_sleep_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusRdData[10]) |-> $past(statusRdData[9] || statusRdData[8]));

  assert_busoff_halt_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busOffPulse && (ctlRdData[12:11] == 2'b01) && (statusRdData == 16'h0000) &&
     (ctlRdData[9:8] != 2'b11)) |=> ((statusRdData == 16'h0200) && (ctlRdData[9:8] == 2'b10)));

endmodule

bind opmode_seq opmode_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busIdle(busIdle), .busOffPulse(busOffPulse),
  .ctlRdData(ctlRdData), .statusRdData(statusRdData)
);

// File: tb/opmode_seq_bench.sv
module opmode_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ctlWrEn;
  logic [15:0] ctlWrData;
  logic        busIdle;
  logic        busOffPulse;
  logic [15:0] ctlRdData;
  logic [15:0] statusRdData;
  logic        cfgOpen;

  int errCnt = 0;
  int chkCnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  opmode_seq #(.SETTLE_CYCLES(SETTLE)) u_opmode_seq (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .busIdle(busIdle), .busOffPulse(busOffPulse), .ctlRdData(ctlRdData),
    .statusRdData(statusRdData), .cfgOpen(cfgOpen)
  );

  // mode codes used by the bench: 0 operation, 1 reset, 2 halt, 3 sleep
  function automatic logic [15:0] stOf(input int m);
    case (m)
      0: return 16'h0000;
      1: return 16'h0100;
      2: return 16'h0200;
      default: return 16'h0400;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    chkCnt++;
    if (got !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic checkMode(input string tag, input int m);
    check(tag, statusRdData, stOf(m));
    check({tag, " R7 cfgOpen"}, {15'd0, cfgOpen}, (m == 1) ? 16'd1 : 16'd0);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; the write lands on the next rising edge
  task automatic wr(input logic [15:0] d);
    ctlWrEn = 1'b1;
    ctlWrData = d;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; ctlWrEn = 1'b0; ctlWrData = '0; busIdle = 1'b1; busOffPulse = 1'b0;
    tick(3);
    check("R1 ctl in reset", ctlRdData, 16'h0500);
    checkMode("R1 status in reset", 3);
    rstN = 1'b1;
    tick(1);
    check("R1 ctl after reset", ctlRdData, 16'h0500);
    checkMode("R1 status after reset", 3);

    // R9: wake from sleep into reset
    wr(16'h0100);
    tick(SETTLE - 1);
    checkMode("R9 still sleep", 3);
    tick(1);
    checkMode("R9 woke to reset", 1);

    // R6: format bits writable in reset, masked bits read zero
    wr(16'hF1FB);
    check("R6 write in reset", ctlRdData, 16'h110B);
    wr(16'h0004);
    check("R6 second write in reset", ctlRdData, 16'h0004);
    tick(SETTLE + 1);
    checkMode("R3 reached operation", 0);
    wr(16'h000B);
    check("R6 locked in operation", ctlRdData, 16'h0004);

    // R3/R4/R2 sweep: every start mode against every request code
    for (int from = 0; from < 3; from++) begin
      for (int req = 0; req < 4; req++) begin
        int expMode;
        busIdle = 1'b1;
        wr(16'h0300);
        tick(2);
        if (from != 1) begin
          wr((from == 0) ? 16'h0000 : 16'h0200);
          tick(SETTLE + 1);
        end
        checkMode("R3 sweep setup", from);
        wr(16'(req << 8));
        expMode = (req == 3) ? 1 : req;
        if (expMode == from) begin
          tick(SETTLE + 1);
          checkMode("R3 sweep no change", from);
        end else if (req == 3) begin
          tick(1);
          checkMode("R4 sweep forced", 1);
        end else begin
          tick(SETTLE - 1);
          checkMode("R3 sweep before settle", from);
          tick(1);
          checkMode("R3 sweep at settle", expMode);
        end
      end
    end

    // R5: plain reset held off by busy bus
    wr(16'h0300); tick(2);
    wr(16'h0000); tick(SETTLE + 1);
    busIdle = 1'b0;
    wr(16'h0100);
    tick(SETTLE + 3);
    checkMode("R5 held while busy", 0);
    busIdle = 1'b1;
    tick(1);
    checkMode("R5 commits when idle", 1);

    // R4: forced reset ignores busy bus
    wr(16'h0000); tick(SETTLE + 1);
    checkMode("R4 in operation", 0);
    busIdle = 1'b0;
    wr(16'h0300);
    tick(1);
    checkMode("R4 forced while busy", 1);
    busIdle = 1'b1;

    // R11: retarget before settle restarts count
    wr(16'h0200);
    wr(16'h0000);
    tick(SETTLE - 1);
    checkMode("R11 no early change", 1);
    tick(1);
    checkMode("R11 new target commits", 0);

    // R10: bus-off with auto-halt recovery
    wr(16'h0800);
    busOffPulse = 1'b1;
    tick(1);
    busOffPulse = 1'b0;
    checkMode("R10 halted on bus-off", 2);
    check("R10 request bits", {11'd0, ctlRdData[12:8]}, 16'h000A);
    wr(16'h1000);
    tick(SETTLE + 1);
    checkMode("R10 back in operation", 0);
    busOffPulse = 1'b1;
    tick(1);
    busOffPulse = 1'b0;
    tick(2);
    checkMode("R10 pulse ignored", 0);

    // R8: sleep bit ignored in operation, then sleep via halt
    wr(16'h0400);
    tick(SETTLE + 3);
    checkMode("R8 sleep ignored in operation", 0);
    wr(16'h0600);
    tick(SETTLE);
    checkMode("R8 halt first", 2);
    tick(SETTLE - 1);
    checkMode("R8 still halt", 2);
    tick(1);
    checkMode("R8 sleep reached", 3);

    // R9: wake into operation
    wr(16'h0000);
    tick(SETTLE - 1);
    checkMode("R9 still sleep", 3);
    tick(1);
    checkMode("R9 woke to operation", 0);

    finishRun();
  end

endmodule